// File: doc/BRIEF.md
# Tiled Background Fetch Sequencer

This block schedules the video-memory reads for a renderer that draws three tiled background layers. All reads share one memory bus and one tile is fetched at a time. The eight pixel clocks of each 8-pixel period give eight read slots. Layers 1 and 2 are four bits per pixel: each gets one slot for its tilemap entry and two slots for its two pattern words. Layer 3 is two bits per pixel: it gets one tilemap slot and one pattern slot. The eight slots are all used, so no slot is left free for other bus users during active display.

Every pattern read is indirect. The block first reads the layer's tilemap entry and stores it. In the next slot it builds the pattern address from that entry, the fine row and the layer's tile base. The words fetched during a period are held in working registers. They are copied to the output registers in one step at the 8-pixel boundary, so the downstream shifters load a complete set for the next tile.

The sequencer is a state machine with these states:
- `S_IDLE`: no reads.
- `S_L1_MAP`, `S_L1_P0`, `S_L1_P1`: layer 1 map entry, then its two pattern words.
- `S_L2_MAP`, `S_L2_P0`, `S_L2_P1`: layer 2 map entry, then its two pattern words.
- `S_L3_MAP`, `S_L3_PAT`: layer 3 map entry, then its single pattern word.

Transitions:
- `S_IDLE` goes to `S_L1_MAP` when `active` is high and `pix_x[2:0]` is 7.
- Each slot state goes to the next slot in the order listed above.
- `S_L3_PAT` goes back to `S_L1_MAP`.
- Every state goes to `S_IDLE` on any clock where `active` is low.

Top module: `bgf_fetch_seq`

## Requirements
- R1: While reset is held and after it is released: the state is idle, `mem_rd` is 0, `shift_load` is 0 and all pattern outputs are 0.
- R2: While active, the slots repeat in a fixed order with `mem_rd` high in all eight. The order is L1 map, L1 word 0, L1 word 1, L2 map, L2 word 0, L2 word 1, L3 map, L3 word. The slot in the cycle where `pix_x[2:0]`=k is slot k.
- R3: In a map slot of layer l, the address is `map_base[l] + {trow[4:0], tcol[4:0]}`, computed modulo 2^16.
- R4: In word slot w (0 or 1) of layer 1 or 2, the address is `tile_base[l] + num*16 + fine*2 + w`. Here `num` is bits [9:0] of the map entry read in that layer's map slot.
- R5: In the layer 3 word slot, the address is `tile_base[2] + num*8 + fine`.
- R6: The pattern outputs change only at the clock edge that ends the L3 word slot. At that edge:
  - `pat_l1` and `pat_l2` take {word 1, word 0} of the current period.
  - `pat_l3` takes the L3 word.
  - `shift_load` is high for exactly the one following cycle.
- R7: When `active` is low at a clock edge, the next cycle is idle with `mem_rd` 0. The pattern outputs keep their values, including when the drop interrupts a period.
- R8: From idle, fetching starts only after a cycle with `active` high and `pix_x[2:0]`=7. The next cycle is then the L1 map slot.
- R9: Tile column and row for layer l:
  - `tcol = (pix_x>>3) + 1 + (scroll_x[l]>>3)` mod 32, so the fetch is for the next tile.
  - With `v = (pix_y + scroll_y[l])` mod 512: `trow = v>>3` mod 32 and `fine = v[2:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | 1 | Active display window |
| pix_x | input | 9 | Horizontal pixel count |
| pix_y | input | 9 | Current line |
| scroll_x | input | 3x9 | Horizontal scroll per layer |
| scroll_y | input | 3x9 | Vertical scroll per layer |
| map_base | input | 3x16 | Tilemap base address per layer |
| tile_base | input | 3x16 | Pattern base address per layer |
| rd_data | input | 16 | Memory read data, valid in the same slot as the address |
| mem_addr | output | 16 | Memory word address |
| mem_rd | output | 1 | Read strobe |
| pat_l1 | output | 32 | Layer 1 pattern words {word 1, word 0} |
| pat_l2 | output | 32 | Layer 2 pattern words {word 1, word 0} |
| pat_l3 | output | 16 | Layer 3 pattern word |
| shift_load | output | 1 | One-cycle pulse when new pattern words are loaded |

## Verification
The assertions check the following on every cycle:
- The strobe stops the cycle after `active` drops.
- Fetching starts only from a pixel phase of 7.
- The L3 word slot wraps back to the L1 map slot.
- The load pulse appears only after an L3 word slot, and the pattern outputs stay stable at all other times.

Only the bench scenarios can show that the addresses are correct. This covers the indirect tile-number path, the scroll arithmetic with its wraparound, and the packing of captured words into the outputs. The bench checks these against values it computes itself from a memory function.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
    localparam int NUM_LAYERS = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_L1_MAP, S_L1_P0, S_L1_P1,
        S_L2_MAP, S_L2_P0, S_L2_P1,
        S_L3_MAP, S_L3_PAT
    } slot_e;
endpackage

// File: rtl/bgf_slot_fsm.sv
module bgf_slot_fsm
    import bgf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [2:0] phase,
    output slot_e      state_q
);
    slot_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = S_IDLE;
        if (active) begin
            unique case (state_q)
                S_IDLE:   state_d = (phase == 3'd7) ? S_L1_MAP : S_IDLE;
                S_L1_MAP: state_d = S_L1_P0;
                S_L1_P0:  state_d = S_L1_P1;
                S_L1_P1:  state_d = S_L2_MAP;
                S_L2_MAP: state_d = S_L2_P0;
                S_L2_P0:  state_d = S_L2_P1;
                S_L2_P1:  state_d = S_L3_MAP;
                S_L3_MAP: state_d = S_L3_PAT;
                S_L3_PAT: state_d = S_L1_MAP;
                default:  state_d = S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bgf_addr_gen.sv
module bgf_addr_gen
    import bgf_pkg::*;
#(
    parameter int XW   = 9,
    parameter int YW   = 9,
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int MAPW = 5,
    parameter int NUMW = 10
) (
    input  slot_e                         state,
    input  logic [XW-1:0]                 pix_x,
    input  logic [YW-1:0]                 pix_y,
    input  logic [NUM_LAYERS-1:0][XW-1:0] scroll_x,
    input  logic [NUM_LAYERS-1:0][YW-1:0] scroll_y,
    input  logic [NUM_LAYERS-1:0][AW-1:0] map_base,
    input  logic [NUM_LAYERS-1:0][AW-1:0] tile_base,
    input  logic [DW-1:0]                 map_entry,
    output logic [AW-1:0]                 mem_addr,
    output logic                          mem_rd
);
    localparam int ROWS     = 8;
    localparam int SH_WIDE  = $clog2(ROWS * 2);
    localparam int SH_NARROW = $clog2(ROWS);

    logic [1:0]      li;
    logic [1:0]      kind;   // 0 map, 1 word0, 2 word1, 3 narrow word
    logic [MAPW-1:0] tcol, trow;
    logic [YW-1:0]   vpos;
    logic [2:0]      fine;
    logic [NUMW-1:0] num;

    always_comb begin
        li   = 2'd0;
        kind = 2'd0;
        unique case (state)
            S_L1_MAP: begin li = 2'd0; kind = 2'd0; end
            S_L1_P0:  begin li = 2'd0; kind = 2'd1; end
            S_L1_P1:  begin li = 2'd0; kind = 2'd2; end
            S_L2_MAP: begin li = 2'd1; kind = 2'd0; end
            S_L2_P0:  begin li = 2'd1; kind = 2'd1; end
            S_L2_P1:  begin li = 2'd1; kind = 2'd2; end
            S_L3_MAP: begin li = 2'd2; kind = 2'd0; end
            S_L3_PAT: begin li = 2'd2; kind = 2'd3; end
            default:  begin li = 2'd0; kind = 2'd0; end
        endcase
    end

    always_comb begin
        tcol = MAPW'(pix_x >> 3) + MAPW'(1) + MAPW'(scroll_x[li] >> 3);
        vpos = pix_y + scroll_y[li];
        trow = MAPW'(vpos >> 3);
        fine = vpos[2:0];
        num  = map_entry[NUMW-1:0];
        mem_rd = (state != S_IDLE);
        unique case (kind)
            2'd0: mem_addr = map_base[li] + AW'({trow, tcol});
            2'd1: mem_addr = tile_base[li] + (AW'(num) << SH_WIDE) + (AW'(fine) << 1);
            2'd2: mem_addr = tile_base[li] + (AW'(num) << SH_WIDE) + (AW'(fine) << 1) + AW'(1);
            default: mem_addr = tile_base[li] + (AW'(num) << SH_NARROW) + AW'(fine);
        endcase
    end
endmodule

// File: rtl/bgf_pattern_buf.sv
module bgf_pattern_buf
    import bgf_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         state,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] map_entry,
    output logic [2*DW-1:0] pat_l1,
    output logic [2*DW-1:0] pat_l2,
    output logic [DW-1:0] pat_l3,
    output logic          shift_load
);
    logic [DW-1:0] w1_0, w1_1, w2_0, w2_1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_entry  <= '0;
            w1_0 <= '0; w1_1 <= '0; w2_0 <= '0; w2_1 <= '0;
            pat_l1 <= '0; pat_l2 <= '0; pat_l3 <= '0;
            shift_load <= 1'b0;
        end else begin
            shift_load <= 1'b0;
            unique case (state)
                S_L1_MAP, S_L2_MAP, S_L3_MAP: map_entry <= rd_data;
                S_L1_P0: w1_0 <= rd_data;
                S_L1_P1: w1_1 <= rd_data;
                S_L2_P0: w2_0 <= rd_data;
                S_L2_P1: w2_1 <= rd_data;
                S_L3_PAT: begin
                    pat_l1     <= {w1_1, w1_0};
                    pat_l2     <= {w2_1, w2_0};
                    pat_l3     <= rd_data;
                    shift_load <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bgf_fetch_seq.sv
module bgf_fetch_seq
    import bgf_pkg::*;
#(
    parameter int XW = 9,
    parameter int YW = 9,
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          active,
    input  logic [XW-1:0]                 pix_x,
    input  logic [YW-1:0]                 pix_y,
    input  logic [NUM_LAYERS-1:0][XW-1:0] scroll_x,
    input  logic [NUM_LAYERS-1:0][YW-1:0] scroll_y,
    input  logic [NUM_LAYERS-1:0][AW-1:0] map_base,
    input  logic [NUM_LAYERS-1:0][AW-1:0] tile_base,
    input  logic [DW-1:0]                 rd_data,
    output logic [AW-1:0]                 mem_addr,
    output logic                          mem_rd,
    output logic [2*DW-1:0]               pat_l1,
    output logic [2*DW-1:0]               pat_l2,
    output logic [DW-1:0]                 pat_l3,
    output logic                          shift_load
);
    slot_e         state_q;
    logic [DW-1:0] map_entry;

    bgf_slot_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active),
        .phase(pix_x[2:0]), .state_q(state_q)
    );

    bgf_addr_gen #(.XW(XW), .YW(YW), .AW(AW), .DW(DW)) u_addr (
        .state(state_q), .pix_x(pix_x), .pix_y(pix_y),
        .scroll_x(scroll_x), .scroll_y(scroll_y),
        .map_base(map_base), .tile_base(tile_base),
        .map_entry(map_entry), .mem_addr(mem_addr), .mem_rd(mem_rd)
    );

    bgf_pattern_buf #(.DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n), .state(state_q), .rd_data(rd_data),
        .map_entry(map_entry), .pat_l1(pat_l1), .pat_l2(pat_l2),
        .pat_l3(pat_l3), .shift_load(shift_load)
    );
endmodule

// File: rtl/bgf_fetch_seq_chk.sv
module bgf_fetch_seq_chk
    import bgf_pkg::*;
#(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            active,
    input logic [2:0]      phase,
    input slot_e           state,
    input logic            mem_rd,
    input logic            shift_load,
    input logic [2*DW-1:0] pat_l1,
    input logic [2*DW-1:0] pat_l2,
    input logic [DW-1:0]   pat_l3
);
    // R7: a low active stops reads on the next cycle
    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !mem_rd);

    // R8: leaving idle needs phase 7 and lands in the L1 map slot
    p_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && active && phase == 3'd7) |=> (state == S_L1_MAP));

    p_noentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && phase != 3'd7) |=> (state == S_IDLE));

    // R2: the last slot wraps to the first while active
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_L3_PAT && active) |=> (state == S_L1_MAP && mem_rd));

    // R6: load pulse only after the L3 word slot
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |-> ($past(state) == S_L3_PAT));

    // R6: outputs stay put between boundaries
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_load |-> ($stable(pat_l1) && $stable(pat_l2) && $stable(pat_l3)));
endmodule

bind bgf_fetch_seq bgf_fetch_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .phase(pix_x[2:0]),
    .state(state_q), .mem_rd(mem_rd), .shift_load(shift_load),
    .pat_l1(pat_l1), .pat_l2(pat_l2), .pat_l3(pat_l3)
);

// File: tb/tb_bgf_fetch_seq.sv
`timescale 1ns/1ps
module tb_bgf_fetch_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic active = 1'b0;
    logic [8:0] pix_x = '0, pix_y = '0;
    logic [2:0][8:0]  scroll_x, scroll_y;
    logic [2:0][15:0] map_base, tile_base;
    logic [15:0] rd_data, mem_addr;
    logic mem_rd, shift_load;
    logic [31:0] pat_l1, pat_l2;
    logic [15:0] pat_l3;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    function automatic logic [15:0] memf(input logic [15:0] a);
        return (a ^ 16'h5A3C) + {a[7:0], a[15:8]};
    endfunction

    assign rd_data = memf(mem_addr);

    bgf_fetch_seq dut (
        .clk(clk), .rst_n(rst_n), .active(active), .pix_x(pix_x), .pix_y(pix_y),
        .scroll_x(scroll_x), .scroll_y(scroll_y), .map_base(map_base),
        .tile_base(tile_base), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .pat_l1(pat_l1), .pat_l2(pat_l2), .pat_l3(pat_l3),
        .shift_load(shift_load)
    );

    typedef struct packed {
        logic [8:0]  py;
        logic [8:0]  sx;
        logic [8:0]  sy;
        logic [15:0] mb;
        logic [15:0] tb;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{9'd0,   9'd0,   9'd0,   16'h0000, 16'h4000},
        '{9'd13,  9'd40,  9'd5,   16'h1200, 16'h8000},
        '{9'd250, 9'd500, 9'd260, 16'hF000, 16'hE001},
        '{9'd511, 9'd255, 9'd1,   16'hFFE0, 16'hFFF0}
    };

    function automatic logic [15:0] exp_addr(input int k, input int px, input vec_t v);
        int l, sub, sx, sy, mb, tb, col, vv, row, fr, maddr, num;
        l   = (k < 3) ? 0 : ((k < 6) ? 1 : 2);
        sub = k - 3 * l;
        sx  = (v.sx + 8 * l) & 511;
        sy  = (v.sy + 3 * l) & 511;
        mb  = v.mb + l * 'h400;
        tb  = v.tb + l * 'h2000;
        col = ((px / 8) + 1 + (sx / 8)) % 32;
        vv  = (v.py + sy) & 511;
        row = (vv / 8) % 32;
        fr  = vv % 8;
        maddr = (mb + row * 32 + col) & 'hFFFF;
        if (sub == 0) return 16'(maddr);
        num = memf(16'(maddr)) & 1023;
        if (l < 2) return 16'(tb + num * 16 + fr * 2 + (sub - 1));
        return 16'(tb + num * 8 + fr);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        pix_y = v.py;
        for (int l = 0; l < 3; l++) begin
            scroll_x[l]  = 9'(v.sx + 8 * l);
            scroll_y[l]  = 9'(v.sy + 3 * l);
            map_base[l]  = 16'(v.mb + l * 'h400);
            tile_base[l] = 16'(v.tb + l * 'h2000);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] h1;
        apply(v);
        @(negedge clk); active = 1'b1; pix_x = 9'd7;
        for (int c = 0; c < 16; c++) begin
            int k;
            @(negedge clk); pix_x = 9'(8 + c); #1;
            k = c % 8;
            check("R2 strobe", {31'd0, mem_rd}, 32'd1);
            if (k == 0 || k == 3 || k == 6)
                check("R3 R9 map addr", {16'd0, mem_addr}, {16'd0, exp_addr(k, 8 + c, v)});
            else if (k == 7)
                check("R5 L3 addr", {16'd0, mem_addr}, {16'd0, exp_addr(k, 8 + c, v)});
            else
                check("R4 pattern addr", {16'd0, mem_addr}, {16'd0, exp_addr(k, 8 + c, v)});
            if (c == 0) h1 = pat_l1;
            if (c == 7) check("R6 hold", pat_l1, h1);
            if (c == 8) begin
                check("R6 load", {31'd0, shift_load}, 32'd1);
                check("R6 pat_l1", pat_l1, {memf(exp_addr(2, 8, v)), memf(exp_addr(1, 8, v))});
                check("R6 pat_l2", pat_l2, {memf(exp_addr(5, 8, v)), memf(exp_addr(4, 8, v))});
                check("R6 pat_l3", {16'd0, pat_l3}, {16'd0, memf(exp_addr(7, 8, v))});
            end
            if (c == 9) check("R6 pulse width", {31'd0, shift_load}, 32'd0);
        end
        @(negedge clk); active = 1'b0; pix_x = 9'd24;
        @(negedge clk); #1;
        check("R7 idle strobe", {31'd0, mem_rd}, 32'd0);
        check("R7 hold l3", {16'd0, pat_l3}, {16'd0, memf(exp_addr(7, 16, v))});
    endtask

    initial begin
        apply(VEC[0]);
        @(negedge clk); #1;
        check("R1 strobe in reset", {31'd0, mem_rd}, 32'd0);
        check("R1 pat_l1 in reset", pat_l1, 32'd0);
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 load after reset", {31'd0, shift_load}, 32'd0);
        check("R1 pat_l3 after reset", {16'd0, pat_l3}, 16'd0);

        foreach (VEC[i]) run_vec(VEC[i]);

        // R8: active but phase not 7 keeps idle
        apply(VEC[1]);
        active = 1'b1;
        for (int p = 2; p < 7; p++) begin
            @(negedge clk); pix_x = 9'(p); #1;
            check("R8 no early start", {31'd0, mem_rd}, 32'd0);
        end
        @(negedge clk); pix_x = 9'd7; #1;
        check("R8 idle at phase 7", {31'd0, mem_rd}, 32'd0);
        @(negedge clk); pix_x = 9'd8; #1;
        check("R8 start slot", {16'd0, mem_addr}, {16'd0, exp_addr(0, 8, VEC[1])});

        // R7: drop mid period, outputs keep last period's words
        for (int c = 9; c < 12; c++) begin
            @(negedge clk); pix_x = 9'(c);
        end
        active = 1'b0;
        for (int c = 12; c < 20; c++) begin
            @(negedge clk); pix_x = 9'(c); #1;
            check("R7 no reads", {31'd0, mem_rd}, 32'd0);
        end
        check("R7 pat_l1 kept", pat_l1,
              {memf(exp_addr(2, 16, VEC[3])), memf(exp_addr(1, 16, VEC[3]))});
        check("R7 no load", {31'd0, shift_load}, 32'd0);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk); #1;
        check("R1 pat_l2 cleared", pat_l2, 32'd0);
        check("R1 strobe cleared", {31'd0, mem_rd}, 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule